// File: doc/BRIEF.md
# Look-ahead pipelined second-order IIR section

This block is one recursive second-order filter section. It is rebuilt so that its feedback can be pipelined. The recursion uses only the outputs from four and eight samples back, never the last one or two. This leaves room for registers inside the feedback loop, so the multiply and the add need not close in a single cycle.

The raised-order denominator adds poles that the original section did not have. A seven-tap non-recursive numerator cancels them. The original poles lie inside the unit circle, so their fourth powers are smaller still, and the pipelined recursion keeps a healthy stability margin. The price is more multipliers than a direct-form section, in exchange for a higher clock rate.

The block accepts one signed fixed-point sample per clock, qualified by a valid strobe. It returns one filtered sample per accepted input, a fixed number of cycles later. All nine coefficients are elaboration-time parameters computed offline. Cycles without valid leave the filter state untouched.

Top module: `lookahead_biquad`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `out_sample` is 0. All stored input and output history is zero afterwards.
- R2: For accepted samples x and outputs y (both signed 16-bit), the block computes y[n] = Q((b0·x[n] + … + b6·x[n-6] − c4·y[n-4] − c8·y[n-8]) / 2^14).
  - The coefficients are signed 16-bit values with 14 fraction bits.
  - b_k sits at bits [16k+15:16k] of `NUM_COEF`, `DEN_NEAR` is c4 and `DEN_FAR` is c8.
- R3: Q rounds to the nearest integer, with exact halves going toward +infinity. That is, floor(v + 0.5): +0.5 gives 1, −0.5 gives 0, −1.5 gives −1.
- R4: Q saturates to the range −32768 to 32767 instead of wrapping.
- R5: Every sample taken with `in_valid` high produces exactly one output with `out_valid` high, three clock cycles later. Samples may arrive on every cycle. `out_valid` is never high otherwise.
- R6: On cycles with `in_valid` low, `in_sample` is ignored and no history advances. The output sequence depends only on the sequence of accepted samples, whatever gaps separate them.
- R7: `out_sample` holds its last value on every cycle where `out_valid` is low.
- R8: The default coefficients realise a unity-DC-gain all-pole section with a double pole at 0.5, which is y[n] = 0.25·x[n] + y[n-1] − 0.25·y[n-2].
  - The defaults are b = 4096, 4096, 3072, 2048, 768, 256, 64; c4 = −2048; c8 = 64.
  - The impulse response of the block lies within 3 LSB of that section's exact response.
- R9: As long as every accepted sample since reset has been zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_sample` for this cycle |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | High for one cycle per produced sample |
| out_sample | output | DATA_W | Signed filtered sample, held between outputs |

## Verification
A wrong recursion index or a misaligned history shows up at the ports from the fifth accepted sample onward. It shows as a slowly growing mismatch against the bench's sample-by-sample model, so a long back-to-back run is compared on every cycle. Tap ordering or coefficient slicing errors change the very first outputs of an impulse. A history that advances on idle cycles only diverges when gaps appear, which is why the same comparison is repeated with irregular valid patterns and with junk driven on the data input during the gaps. Rounding and clipping faults appear on the first output after a chosen single sample, so they are probed directly.

// File: rtl/lookahead_biquad_pkg.sv
package lookahead_biquad_pkg;

   // smallest look-ahead factor the two-register feedback loop supports
   localparam int LA_MIN = 2;

   // numerator length needed to cancel the extra look-ahead poles
   function automatic int num_taps(input int la);
      return 2 * la - 1;
   endfunction

   // output history needed for the far feedback term
   function automatic int hist_depth(input int la);
      return 2 * la;
   endfunction

endpackage

// File: rtl/lookahead_biquad_fir.sv
module lookahead_biquad_fir #(
   parameter int DATA_W   = 16,
   parameter int COEF_W   = 16,
   parameter int NUM_TAPS = 7,
   parameter logic [NUM_TAPS*COEF_W-1:0] NUM_COEF = '0
) (
   input  logic                                        clk,
   input  logic                                        rst,
   input  logic                                        shift_en,
   input  logic [DATA_W-1:0]                           sample,
   input  logic                                        mul_en,
   output logic [NUM_TAPS-1:0][DATA_W+COEF_W-1:0]      prod
);
   localparam int PROD_W = DATA_W + COEF_W;

   // tap line, index 0 is the newest accepted sample
   logic [NUM_TAPS-1:0][DATA_W-1:0] tap_q;

   if (NUM_TAPS > 1) begin : g_line
      always_ff @(posedge clk) begin
         if (rst)
            tap_q <= '0;
         else if (shift_en)
            tap_q <= {tap_q[NUM_TAPS-2:0], sample};
      end
   end else begin : g_single
      always_ff @(posedge clk) begin
         if (rst)
            tap_q <= '0;
         else if (shift_en)
            tap_q <= sample;
      end
   end

   for (genvar k = 0; k < NUM_TAPS; k++) begin : g_mul
      localparam logic [COEF_W-1:0] CK = NUM_COEF[k*COEF_W +: COEF_W];
      logic signed [PROD_W-1:0] x_ext;
      logic signed [PROD_W-1:0] c_ext;
      logic        [PROD_W-1:0] p_q;

      assign x_ext = {{COEF_W{tap_q[k][DATA_W-1]}}, tap_q[k]};
      assign c_ext = {{DATA_W{CK[COEF_W-1]}}, CK};

      always_ff @(posedge clk) begin
         if (rst)
            p_q <= '0;
         else if (mul_en)
            p_q <= x_ext * c_ext;
      end

      assign prod[k] = p_q;
   end

endmodule

// File: rtl/lookahead_biquad_recur.sv
module lookahead_biquad_recur #(
   parameter int DATA_W   = 16,
   parameter int COEF_W   = 16,
   parameter int LA_DEPTH = 4,
   parameter logic [COEF_W-1:0] DEN_NEAR = '0,
   parameter logic [COEF_W-1:0] DEN_FAR  = '0
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 wr_en,
   input  logic [DATA_W-1:0]                    y_new,
   input  logic                                 pending,
   input  logic                                 mul_en,
   output logic [1:0][DATA_W+COEF_W-1:0]        fb_prod,
   output logic [DATA_W-1:0]                    newest
);
   localparam int PROD_W = DATA_W + COEF_W;
   localparam int HD     = lookahead_biquad_pkg::hist_depth(LA_DEPTH);

   // output history, index 0 is the most recent written output
   logic [HD-1:0][DATA_W-1:0] hist_q;

   always_ff @(posedge clk) begin
      if (rst)
         hist_q <= '0;
      else if (wr_en)
         hist_q <= {hist_q[HD-2:0], y_new};
   end

   assign newest = hist_q[0];

   // term 0 reaches back LA_DEPTH samples, term 1 twice as far.
   // One older sample may still sit in the adder stage (pending),
   // in which case the wanted output is one slot closer to the head.
   for (genvar j = 0; j < 2; j++) begin : g_fb
      localparam int          LAG = (j + 1) * LA_DEPTH;
      localparam logic [COEF_W-1:0] CJ = (j == 0) ? DEN_NEAR : DEN_FAR;
      logic        [DATA_W-1:0] y_sel;
      logic signed [PROD_W-1:0] y_ext;
      logic signed [PROD_W-1:0] c_ext;
      logic        [PROD_W-1:0] p_q;

      assign y_sel = pending ? hist_q[LAG-2] : hist_q[LAG-1];
      assign y_ext = {{COEF_W{y_sel[DATA_W-1]}}, y_sel};
      assign c_ext = {{DATA_W{CJ[COEF_W-1]}}, CJ};

      always_ff @(posedge clk) begin
         if (rst)
            p_q <= '0;
         else if (mul_en)
            p_q <= y_ext * c_ext;
      end

      assign fb_prod[j] = p_q;
   end

endmodule

// File: rtl/lookahead_biquad_quant.sv
module lookahead_biquad_quant #(
   parameter int DATA_W   = 16,
   parameter int PROD_W   = 32,
   parameter int ACC_W    = 40,
   parameter int FRAC     = 14,
   parameter int NUM_TAPS = 7
) (
   input  logic [NUM_TAPS-1:0][PROD_W-1:0] num_prod,
   input  logic [1:0][PROD_W-1:0]          fb_prod,
   output logic [DATA_W-1:0]               y_q
);
   localparam logic signed [ACC_W-1:0] Q_MAX = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] Q_MIN = -Q_MAX - ACC_W'(1);

   function automatic logic signed [ACC_W-1:0] sext(input logic [PROD_W-1:0] v);
      return {{(ACC_W-PROD_W){v[PROD_W-1]}}, v};
   endfunction

   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] scaled;

   always_comb begin
      acc = '0;
      for (int k = 0; k < NUM_TAPS; k++)
         acc = acc + sext(num_prod[k]);
      acc = acc - sext(fb_prod[0]) - sext(fb_prod[1]);
   end

   if (FRAC > 0) begin : g_round
      localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (FRAC - 1));
      assign scaled = (acc + HALF) >>> FRAC;
   end else begin : g_plain
      assign scaled = acc;
   end

   always_comb begin
      if (scaled > Q_MAX)
         y_q = Q_MAX[DATA_W-1:0];
      else if (scaled < Q_MIN)
         y_q = Q_MIN[DATA_W-1:0];
      else
         y_q = scaled[DATA_W-1:0];
   end

endmodule

// File: rtl/lookahead_biquad.sv
module lookahead_biquad
   import lookahead_biquad_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int COEF_W    = 16,
   parameter int COEF_FRAC = 14,
   parameter int ACC_W     = 40,
   parameter int LA_DEPTH  = 4,
   parameter logic [num_taps(LA_DEPTH)*COEF_W-1:0] NUM_COEF =
      {16'd64, 16'd256, 16'd768, 16'd2048, 16'd3072, 16'd4096, 16'd4096},
   parameter logic [COEF_W-1:0] DEN_NEAR = 16'hF800,
   parameter logic [COEF_W-1:0] DEN_FAR  = 16'h0040
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_sample,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_sample
);
   localparam int NT     = num_taps(LA_DEPTH);
   localparam int PROD_W = DATA_W + COEF_W;

   if (LA_DEPTH < LA_MIN) begin : g_err_la
      $error("look-ahead factor below the loop register count");
   end
   if (DATA_W < 2 || DATA_W > 31) begin : g_err_dw
      $error("DATA_W out of supported range");
   end
   if (ACC_W < PROD_W + $clog2(NT + 2)) begin : g_err_acc
      $error("accumulator too narrow for the product sum");
   end
   if (COEF_FRAC < 0 || COEF_FRAC >= ACC_W) begin : g_err_frac
      $error("COEF_FRAC out of range");
   end

   // stage valids: s1 = taps loaded, s2 = products loaded
   logic s1_vld, s2_vld;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld    <= 1'b0;
         s2_vld    <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         s1_vld    <= in_valid;
         s2_vld    <= s1_vld;
         out_valid <= s2_vld;
      end
   end

   logic [NT-1:0][PROD_W-1:0] num_prod;
   logic [1:0][PROD_W-1:0]    fb_prod;
   logic [DATA_W-1:0]         y_next;

   lookahead_biquad_fir #(
      .DATA_W   (DATA_W),
      .COEF_W   (COEF_W),
      .NUM_TAPS (NT),
      .NUM_COEF (NUM_COEF)
   ) u_fir (
      .clk      (clk),
      .rst      (rst),
      .shift_en (in_valid),
      .sample   (in_sample),
      .mul_en   (s1_vld),
      .prod     (num_prod)
   );

   lookahead_biquad_recur #(
      .DATA_W   (DATA_W),
      .COEF_W   (COEF_W),
      .LA_DEPTH (LA_DEPTH),
      .DEN_NEAR (DEN_NEAR),
      .DEN_FAR  (DEN_FAR)
   ) u_recur (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (s2_vld),
      .y_new    (y_next),
      .pending  (s2_vld),
      .mul_en   (s1_vld),
      .fb_prod  (fb_prod),
      .newest   (out_sample)
   );

   lookahead_biquad_quant #(
      .DATA_W   (DATA_W),
      .PROD_W   (PROD_W),
      .ACC_W    (ACC_W),
      .FRAC     (COEF_FRAC),
      .NUM_TAPS (NT)
   ) u_quant (
      .num_prod (num_prod),
      .fb_prod  (fb_prod),
      .y_q      (y_next)
   );

endmodule

// File: rtl/lookahead_biquad_chk.sv
module lookahead_biquad_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_sample,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_sample
);
   logic [1:0] since_q;
   logic       nz_seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_q   <= '0;
         nz_seen_q <= 1'b0;
      end else begin
         if (since_q != 2'd3)
            since_q <= since_q + 2'd1;
         if (in_valid && in_sample != '0)
            nz_seen_q <= 1'b1;
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && out_sample == '0)); // R1

   AST_OUT_FROM_IN: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, 3)); // R5

   AST_IN_TO_OUT: assert property (@(posedge clk) disable iff (rst)
      (since_q == 2'd3 && $past(in_valid, 3)) |-> out_valid); // R5

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (since_q != 2'd0 && !out_valid) |-> $stable(out_sample)); // R7

   AST_ZERO_STATE: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !nz_seen_q) |-> out_sample == '0); // R9

endmodule

bind lookahead_biquad lookahead_biquad_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .in_sample  (in_sample),
   .out_valid  (out_valid),
   .out_sample (out_sample)
);

// File: tb/lookahead_biquad_bench.sv
`timescale 1ns/1ps
module lookahead_biquad_bench;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic [15:0]       in_sample = '0;
   logic              ov [2];
   logic [15:0]       od [2];

   always #2.5 clk = ~clk;

   lookahead_biquad u_lookahead_biquad (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(ov[0]), .out_sample(od[0]));

   lookahead_biquad #(
      .NUM_COEF({16'd0, 16'd0, 16'd0, 16'd0, 16'd32767, 16'd32767, 16'd8192}),
      .DEN_NEAR(16'd0), .DEN_FAR(16'd0)
   ) u_lookahead_biquad_sat (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(ov[1]), .out_sample(od[1]));

   int checks = 0;
   int errors = 0;
   string cur_req = "R2";

   // behavioural model state per instance
   int cb [2][7];
   int cn [2];
   int cf [2];
   int mx [2][7];
   int my [2][8];
   bit pipe_v [3];
   int pipe_d [2][3];
   int last_out [2];
   bit capture = 0;
   int imp_q [$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int u = 0; u < 2; u++) begin
         for (int k = 0; k < 7; k++) mx[u][k] = 0;
         for (int k = 0; k < 8; k++) my[u][k] = 0;
         last_out[u] = 0;
         for (int s = 0; s < 3; s++) pipe_d[u][s] = 0;
      end
      for (int s = 0; s < 3; s++) pipe_v[s] = 0;
   endtask

   function automatic int model_step(input int u, input int x);
      longint acc;
      longint r;
      for (int k = 6; k > 0; k--) mx[u][k] = mx[u][k-1];
      mx[u][0] = x;
      acc = 0;
      for (int k = 0; k < 7; k++) acc += longint'(cb[u][k]) * mx[u][k];
      acc -= longint'(cn[u]) * my[u][3];
      acc -= longint'(cf[u]) * my[u][7];
      r = (acc + 8192) >>> 14;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      for (int k = 7; k > 0; k--) my[u][k] = my[u][k-1];
      my[u][0] = int'(r);
      return int'(r);
   endfunction

   task automatic cycle(input bit v, input int x);
      @(negedge clk);
      for (int u = 0; u < 2; u++) begin
         if (pipe_v[2]) begin
            chk(ov[u] == 1'b1, "R5", int'(ov[u]), 1);
            chk($signed(od[u]) == pipe_d[u][2], cur_req, $signed(od[u]), pipe_d[u][2]);
            last_out[u] = pipe_d[u][2];
         end else begin
            chk(ov[u] == 1'b0, "R5", int'(ov[u]), 0);
            chk($signed(od[u]) == last_out[u], "R7", $signed(od[u]), last_out[u]);
         end
      end
      if (capture && ov[0]) imp_q.push_back(int'($signed(od[0])));
      pipe_v[2] = pipe_v[1];
      pipe_v[1] = pipe_v[0];
      pipe_v[0] = v;
      for (int u = 0; u < 2; u++) begin
         pipe_d[u][2] = pipe_d[u][1];
         pipe_d[u][1] = pipe_d[u][0];
         pipe_d[u][0] = v ? model_step(u, x) : 0;
      end
      in_valid  = v;
      in_sample = v ? 16'(x) : 16'h5A5A;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      for (int u = 0; u < 2; u++) begin
         chk(ov[u] == 1'b0, "R1", int'(ov[u]), 0);
         chk(od[u] == 16'd0, "R1", $signed(od[u]), 0);
      end
      model_clear();
      rst = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R5: watchdog expired, got running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R8: default coefficient set of the main instance
      cb[0] = '{4096, 4096, 3072, 2048, 768, 256, 64};
      cn[0] = -2048; cf[0] = 64;
      cb[1] = '{8192, 32767, 32767, 0, 0, 0, 0};
      cn[1] = 0; cf[1] = 0;
      model_clear();
      do_reset();

      // R9: zero stimulus stays zero
      cur_req = "R9";
      for (int i = 0; i < 12; i++) cycle(1, 0);

      // R2: back-to-back varied samples
      cur_req = "R2";
      for (int i = 0; i < 80; i++) cycle(1, int'($urandom_range(40000)) - 20000);
      for (int i = 0; i < 30; i++) cycle(1, (i % 2 == 0) ? 15000 : -15000);

      // R6: irregular gaps with junk data on idle cycles
      cur_req = "R6";
      for (int i = 0; i < 90; i++) cycle((i % 3) != 1 && (i % 7) != 5, int'($urandom_range(30000)) - 15000);
      for (int i = 0; i < 5; i++) cycle(0, 0);

      // R1: history cleared by reset after activity
      do_reset();
      cur_req = "R1";
      for (int i = 0; i < 10; i++) cycle(1, 0);

      // R4: clipping both ways
      cur_req = "R4";
      for (int i = 0; i < 10; i++) cycle(1, 32767);
      for (int i = 0; i < 4; i++) cycle(0, 0);
      chk($signed(od[1]) == 32767, "R4", $signed(od[1]), 32767);
      for (int i = 0; i < 10; i++) cycle(1, -32768);
      for (int i = 0; i < 4; i++) cycle(0, 0);
      chk($signed(od[1]) == -32768, "R4", $signed(od[1]), -32768);

      // R3: half-way rounding on the clip instance (first tap 0.5)
      cur_req = "R3";
      do_reset();
      cycle(1, 1);
      for (int i = 0; i < 3; i++) cycle(0, 0);
      chk($signed(od[1]) == 1, "R3", $signed(od[1]), 1);
      do_reset();
      cycle(1, -1);
      for (int i = 0; i < 3; i++) cycle(0, 0);
      chk($signed(od[1]) == 0, "R3", $signed(od[1]), 0);
      do_reset();
      cycle(1, -3);
      for (int i = 0; i < 3; i++) cycle(0, 0);
      chk($signed(od[1]) == -1, "R3", $signed(od[1]), -1);

      // R8: impulse against the exact original section
      cur_req = "R8";
      do_reset();
      imp_q.delete();
      capture = 1;
      cycle(1, 16384);
      for (int i = 0; i < 19; i++) cycle(1, 0);
      for (int i = 0; i < 4; i++) cycle(0, 0);
      capture = 0;
      chk(imp_q.size() == 20, "R8", imp_q.size(), 20);
      for (int n = 0; n < 16 && n < imp_q.size(); n++) begin
         real ref_v;
         real diff;
         ref_v = 4096.0 * real'(n + 1) / (2.0 ** n);
         diff = real'(imp_q[n]) - ref_v;
         chk(diff <= 3.0 && diff >= -3.0, "R8", imp_q[n], int'(ref_v));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule